// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Core

This block tracks interrupt requests for eight lines and resolves which one the processor is told about. Each line delivers one-cycle request pulses. A pulse on an unmasked line sets that line's pending bit. The block holds a pending register and an in-service register. Its interrupt output is combinational from those two registers. The output is high when the highest pending line has no in-service line at or above it. Higher line numbers always have higher priority.

The processor acknowledges with a one-cycle `ack_i` pulse. The highest pending line wins. Its pending bit moves to in-service, and one cycle later `vec_o` carries the vector base OR-ed with the winning line number, with `vec_valid_o` high. A winning line can be marked in the cascade mask while a slave is attached. In that case the acknowledge goes out on `slv_ack_o` in the same cycle, and the vector the slave presents on `slv_vec_i` is returned in place of the local one.

End-of-interrupt commands clear in-service bits, which can release a blocked request. A specific command names its line. A nonspecific command clears the highest set in-service bit. Mask, vector base, cascade mask and slave presence come from the register file that surrounds the core.

Top module: `irq_prio_core`

## Requirements
- R1: After reset the pending and in-service registers are clear, `irq_o` is 0 and `vec_valid_o` is 0.
- R2: A request pulse on a line whose `mask_i` bit is 1 is discarded. Clearing the mask afterwards does not raise `irq_o`.
- R3: A request pulse on an unmasked line sets its pending bit at the next clock edge, and `irq_o` is high from then on while nothing blocks it.
- R4: `irq_o` is 1 exactly when some line is pending and no in-service bit is set at or above the highest pending line. An in-service line below the requester does not block it.
- R5: `vec_o` is valid in the cycle after an `ack_i` pulse, signalled by `vec_valid_o`. On a local acknowledge it equals `vec_base_i | n`, where n is the highest pending line number (0..7).
- R6: An acknowledge clears the winner's pending bit and sets its in-service bit.
- R7: If the winner's `casc_mask_i` bit is 1 and `slave_present_i` is 1, then `slv_ack_o` is high during the `ack_i` cycle, and the next `vec_o` equals the `slv_vec_i` sampled in that cycle.
- R8: A cascade-marked winner with `slave_present_i` = 0 returns the local vector, and `slv_ack_o` stays 0.
- R9: `eoi_valid_i` with `eoi_specific_i` = 1 clears the in-service bit of `eoi_line_i`.
- R10: `eoi_valid_i` with `eoi_specific_i` = 0 clears the highest-numbered set in-service bit. With none set it has no effect.
- R11: An acknowledge with nothing pending returns `vec_base_i | 7` and leaves both registers unchanged.
- R12: When a new request pulse arrives on the winning line in its acknowledge cycle, the line stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Per-line request pulses |
| mask_i | input | 8 | Per-line mask, 1 discards requests |
| vec_base_i | input | 8 | Vector base OR-ed with the line number |
| casc_mask_i | input | 8 | Lines that lead to a slave controller |
| slave_present_i | input | 1 | A slave is attached |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| eoi_valid_i | input | 1 | End-of-interrupt command strobe |
| eoi_specific_i | input | 1 | 1: specific command, 0: nonspecific |
| eoi_line_i | input | 3 | Line for a specific command |
| slv_vec_i | input | 8 | Vector returned by the slave |
| irq_o | output | 1 | Interrupt request to the processor |
| slv_ack_o | output | 1 | Acknowledge forwarded to the slave |
| vec_o | output | 8 | Acknowledge vector |
| vec_valid_o | output | 1 | `vec_o` valid |

## Verification
The bench first acknowledges with nothing pending and then checks that a lower request stays blocked. A design that altered the in-service register on an empty acknowledge would let that request through. It also issues a nonspecific end-of-interrupt while two lines are in service. A design that cleared the wrong bit would raise `irq_o` at the wrong moment. Cascade acknowledges are run both with and without a slave present, so a core that ignored slave presence would return the slave's vector where the local one is expected. A request that coincides with its own acknowledge must survive, or the second acknowledge would return the base-plus-7 vector instead of the line's.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned IDX_W = $clog2(LINES);
  typedef logic [LINES-1:0] line_vec_t;
  typedef logic [IDX_W-1:0] line_idx_t;
endpackage

// File: rtl/irq_msb_enc.sv
module irq_msb_enc #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // empty input reports the top index
  always_comb begin
    idx_o = IDX_W'(N - 1);
    for (int i = 0; i < int'(N); i++) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/irq_state.sv
module irq_state #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irr_set_i,
  input  logic [N-1:0] irr_clr_i,
  input  logic [N-1:0] isr_set_i,
  input  logic [N-1:0] isr_clr_i,
  output logic [N-1:0] irr_o,
  output logic [N-1:0] isr_o
);
  // set wins over clear on both registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_o <= '0;
      isr_o <= '0;
    end else begin
      irr_o <= (irr_o & ~irr_clr_i) | irr_set_i;
      isr_o <= (isr_o & ~isr_clr_i) | isr_set_i;
    end
  end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int unsigned N_LINES = irq_pkg::LINES,
  parameter int unsigned VEC_W   = 8,
  localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [VEC_W-1:0]   vec_base_i,
  input  logic [N_LINES-1:0] casc_mask_i,
  input  logic               slave_present_i,
  input  logic               ack_i,
  input  logic               eoi_valid_i,
  input  logic               eoi_specific_i,
  input  logic [IDX_W-1:0]   eoi_line_i,
  input  logic [VEC_W-1:0]   slv_vec_i,
  output logic               irq_o,
  output logic               slv_ack_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_valid_o
);
  logic [N_LINES-1:0] irr, isr, ge_top, win_oh, eoi_oh, irr_set;
  logic               irr_any, isr_any, ack_take, eoi_hit;
  logic [IDX_W-1:0]   irr_top, isr_top, eoi_idx;
  logic [VEC_W-1:0]   vec_d;

  irq_msb_enc #(.N(N_LINES), .IDX_W(IDX_W)) u_irr_enc (
    .vec_i(irr), .any_o(irr_any), .idx_o(irr_top)
  );
  irq_msb_enc #(.N(N_LINES), .IDX_W(IDX_W)) u_isr_enc (
    .vec_i(isr), .any_o(isr_any), .idx_o(isr_top)
  );

  // lines at or above the highest pending one
  for (genvar g = 0; g < N_LINES; g++) begin : g_ge
    assign ge_top[g] = (IDX_W'(g) >= irr_top);
  end

  assign irq_o     = irr_any && !(|(isr & ge_top));
  assign ack_take  = ack_i && irr_any;
  assign win_oh    = ack_take ? (N_LINES'(1) << irr_top) : '0;
  assign slv_ack_o = ack_take && casc_mask_i[irr_top] && slave_present_i;
  assign irr_set   = req_i & ~mask_i;

  assign eoi_idx = eoi_specific_i ? eoi_line_i : isr_top;
  assign eoi_hit = eoi_valid_i && (eoi_specific_i || isr_any);
  assign eoi_oh  = eoi_hit ? (N_LINES'(1) << eoi_idx) : '0;

  irq_state #(.N(N_LINES)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irr_set_i(irr_set),
    .irr_clr_i(win_oh),
    .isr_set_i(win_oh),
    .isr_clr_i(eoi_oh),
    .irr_o    (irr),
    .isr_o    (isr)
  );

  assign vec_d = slv_ack_o ? slv_vec_i : (vec_base_i | VEC_W'(irr_top));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      vec_valid_o <= ack_i;
      if (ack_i) vec_o <= vec_d;
    end
  end
endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned VEC_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_LINES-1:0] req_i,
  input logic [N_LINES-1:0] mask_i,
  input logic               slave_present_i,
  input logic               ack_i,
  input logic               eoi_valid_i,
  input logic [VEC_W-1:0]   slv_vec_i,
  input logic               irq_o,
  input logic               slv_ack_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic               vec_valid_o
);
  a_r5_valid_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_valid_o);
  a_r5_valid_only_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(ack_i));
  a_r7_fwd_needs_slave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_ack_o |-> (ack_i && slave_present_i));
  a_r7_slave_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_ack_o |=> (vec_o == $past(slv_vec_i)));
  a_r2_quiet_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !(|(req_i & ~mask_i)) && !eoi_valid_i) |=> !irq_o);
endmodule

bind irq_prio_core irq_prio_core_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_prio_core_tb_top.sv
module irq_prio_core_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] req_i = '0, mask_i = '0, vec_base_i = 8'h20, casc_mask_i = '0;
  logic       slave_present_i = 1'b0, ack_i = 1'b0;
  logic       eoi_valid_i = 1'b0, eoi_specific_i = 1'b0;
  logic [2:0] eoi_line_i = '0;
  logic [7:0] slv_vec_i = 8'h71;
  logic       irq_o, slv_ack_o, vec_valid_o;
  logic [7:0] vec_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk_i = ~clk_i;

  irq_prio_core dut_i (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_req(input logic [7:0] r);
    @(negedge clk_i); req_i = r;
    @(negedge clk_i); req_i = '0;
  endtask

  task automatic eoi(input logic spec, input logic [2:0] line);
    @(negedge clk_i); eoi_valid_i = 1'b1; eoi_specific_i = spec; eoi_line_i = line;
    @(negedge clk_i); eoi_valid_i = 1'b0;
  endtask

  // driver: push expected vector, pulse ack, check forwarding
  task automatic do_ack(input string req, input logic [7:0] exp, input logic exp_fwd,
                        input logic [7:0] same_req);
    @(negedge clk_i);
    exp_q.push_back(exp); tag_q.push_back(req);
    ack_i = 1'b1; req_i = same_req;
    #1 check({req, " slv_ack"}, {7'd0, slv_ack_o}, {7'd0, exp_fwd});
    @(negedge clk_i); ack_i = 1'b0; req_i = '0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && vec_valid_o) begin
      if (exp_q.size() == 0) check("R5 unexpected", vec_o, 8'hxx);
      else check(tag_q.pop_front(), vec_o, exp_q.pop_front());
    end
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 irq", {7'd0, irq_o}, 8'd0);
    check("R1 valid", {7'd0, vec_valid_o}, 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 irq after reset", {7'd0, irq_o}, 8'd0);

    mask_i = 8'h01;
    pulse_req(8'h01);
    check("R2 masked", {7'd0, irq_o}, 8'd0);
    mask_i = 8'h00;
    @(negedge clk_i);
    check("R2 unmask no irq", {7'd0, irq_o}, 8'd0);
    do_ack("R11 empty ack", 8'h27, 1'b0, 8'h00);

    pulse_req(8'h08);
    check("R3 irq raised", {7'd0, irq_o}, 8'd1);
    pulse_req(8'h20);
    do_ack("R5 highest wins", 8'h25, 1'b0, 8'h00);
    check("R4 R6 blocked by higher isr", {7'd0, irq_o}, 8'd0);
    pulse_req(8'h40);
    check("R4 higher not blocked", {7'd0, irq_o}, 8'd1);
    do_ack("R5 line6", 8'h26, 1'b0, 8'h00);
    check("R6 irq low", {7'd0, irq_o}, 8'd0);
    eoi(1'b0, 3'd0);
    check("R10 nonspec clears 6 only", {7'd0, irq_o}, 8'd0);
    eoi(1'b1, 3'd5);
    check("R9 specific eoi", {7'd0, irq_o}, 8'd1);
    do_ack("R5 line3", 8'h23, 1'b0, 8'h00);
    do_ack("R11 empty ack", 8'h27, 1'b0, 8'h00);
    pulse_req(8'h04);
    check("R11 isr unchanged", {7'd0, irq_o}, 8'd0);
    eoi(1'b1, 3'd3);
    check("R9 release", {7'd0, irq_o}, 8'd1);
    do_ack("R5 line2", 8'h22, 1'b0, 8'h00);
    eoi(1'b0, 3'd0);
    eoi(1'b0, 3'd0);
    check("R10 empty nonspec", {7'd0, irq_o}, 8'd0);

    casc_mask_i = 8'h04; slave_present_i = 1'b1;
    pulse_req(8'h08);
    do_ack("R7 non-cascade line", 8'h23, 1'b0, 8'h00);
    eoi(1'b0, 3'd0);
    pulse_req(8'h04);
    do_ack("R7 cascade", 8'h71, 1'b1, 8'h00);
    eoi(1'b0, 3'd0);
    slave_present_i = 1'b0;
    pulse_req(8'h04);
    do_ack("R8 no slave", 8'h22, 1'b0, 8'h00);
    eoi(1'b0, 3'd0);
    casc_mask_i = 8'h00;

    pulse_req(8'h10);
    do_ack("R12 ack", 8'h24, 1'b0, 8'h10);
    check("R12 blocked by own isr", {7'd0, irq_o}, 8'd0);
    eoi(1'b0, 3'd0);
    check("R12 still pending", {7'd0, irq_o}, 8'd1);
    do_ack("R12 second ack", 8'h24, 1'b0, 8'h00);
    eoi(1'b0, 3'd0);

    repeat (3) @(negedge clk_i);
    check("R5 all vectors seen", 8'(exp_q.size()), 8'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule